// File: doc/BRIEF.md
# Gated Bit Error Counter

This block sits behind a serial receiver and its reference pattern source. On every clock where the valid strobe is high it takes one received bit and the bit that was expected in that position. It compares the two and keeps saturating counts of compared bits and of mismatches. Mismatches are split by the value the reference bit had, and a combined count is also kept. A single-bit pulse output condenses the error stream into fixed 128-bit segments, so that an instrument or a slow monitor can see where errors happened without reading the counters.

A gate input lets a test setup blank parts of the stream, for example the gaps between bursts in a loop test. Blanking always covers whole units of 512 valid bits. After a blanked span the gate is not honoured again until a set number of bits has been compared, so the receive side has time to settle before the next burst. A synchronous clear starts a new measurement.

Top module: `gated_err_counter`

## Requirements
- R1: After reset, and on the clock after a cycle with `clr` high, every counter reads 0 and `err_pulse` is low. `clr` overrides any bit presented in the same cycle.
- R2: Each bit with `bit_vld` high that is not blanked adds exactly 1 to `bits_cmp`. Cycles with `bit_vld` low change no counter, whatever `rx_bit` and `exp_bit` hold.
- R3: A compared bit with `rx_bit != exp_bit` adds 1 to `err_exp0` when `exp_bit` is 0, and to `err_exp1` when `exp_bit` is 1. It also adds 1 to `err_all`, so that `err_all` equals `err_exp0 + err_exp1` while it is below its maximum.
- R4: Valid bits are numbered from 0 after a clear, blanked bits included, and each run of 128 numbers starting at a multiple of 128 is one segment. If any compared bit of a segment mismatched, `err_pulse` goes high on the clock after the segment's last bit. This holds when the segment's last bit is itself blanked.
- R5: Each such pulse stays high for exactly 128 clock periods, counted from the clock on which it rises, unless a clear ends it early.
- R6: A valid bit that sees `gate` high while the block is armed starts a blanked span. The span is made of units of 512 valid bits counted from that bit. It ends with the first unit whose last bit sees `gate` low, so a gate that drops midway keeps blanking to the end of the current unit.
- R7: Blanked bits change no counter, and a mismatch on a blanked bit does not by itself raise `err_pulse`.
- R8: The block is armed after reset and after a clear. When a blanked span ends it disarms, and it becomes armed again once 2560 compared bits have been counted since that end. While disarmed, `gate` is ignored and bits are compared.
- R9: Every counter stops at its all-ones maximum instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the measurement |
| bit_vld | input | 1 | Qualifies `rx_bit` and `exp_bit` in this cycle |
| rx_bit | input | 1 | Received bit |
| exp_bit | input | 1 | Expected reference bit |
| gate | input | 1 | Blanking request, active high |
| bits_cmp | output | CNT_W | Saturating count of compared bits |
| err_exp0 | output | ERR_W | Saturating count of errors on bits expected as 0 |
| err_exp1 | output | ERR_W | Saturating count of errors on bits expected as 1 |
| err_all | output | ERR_W | Saturating count of all errors |
| err_pulse | output | 1 | Segment error pulse, active high |

## Verification
The two functions that can meet in one cycle are the closing of a 128-bit segment and the start of a blanked span. The gate is raised exactly on bit 127 of a segment, and that bit carries a mismatch. An earlier bit of the same segment also mismatches. The result is correct if the pulse still rises on the next clock and the error and bit counts ignore the blanked bit. A clear is then given while that pulse is high, and the pulse must drop on the following clock.

// File: rtl/gec_pkg.sv
package gec_pkg;

  // Index of each error counter kind.
  localparam int KIND_EXP0 = 0;
  localparam int KIND_EXP1 = 1;
  localparam int KIND_ANY  = 2;
  localparam int NUM_KINDS = 3;

  // Which error counters a compared bit advances.
  function automatic logic [NUM_KINDS-1:0] miss_vec(input logic cmp,
                                                     input logic rx,
                                                     input logic exp);
    logic m;
    m = cmp & (rx ^ exp);
    miss_vec = '0;
    miss_vec[KIND_EXP0] = m & ~exp;
    miss_vec[KIND_EXP1] = m & exp;
    miss_vec[KIND_ANY]  = m;
  endfunction

  // True when idx is the last position of a run of size entries.
  function automatic logic at_last(input int unsigned idx,
                                   input int unsigned size);
    at_last = (idx == size - 1);
  endfunction

endpackage

// File: rtl/gec_sat_cnt.sv
module gec_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      value <= '0;
    else if (clr)
      value <= '0;
    else if (inc && value != TOP)
      value <= value + W'(1);
  end
endmodule

// File: rtl/gec_blank.sv
module gec_blank
  import gec_pkg::*;
#(
  parameter int UNIT_BITS  = 512,
  parameter int REARM_BITS = 2560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic gate,
  output logic blank_now,
  output logic span_close
);
  localparam int UW = $clog2(UNIT_BITS);
  localparam int RW = $clog2(REARM_BITS + 1);
  localparam logic [RW-1:0] REARM_FULL = RW'(REARM_BITS);

  logic          in_span;
  logic [UW-1:0] unit_idx;
  logic [RW-1:0] rearm_cnt;
  logic          armed;

  assign armed      = (rearm_cnt == REARM_FULL);
  assign blank_now  = vld & (in_span | (gate & armed));
  assign span_close = blank_now & ~gate & at_last(int'(unit_idx), UNIT_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_span   <= 1'b0;
      unit_idx  <= '0;
      rearm_cnt <= REARM_FULL;
    end else if (clr) begin
      in_span   <= 1'b0;
      unit_idx  <= '0;
      rearm_cnt <= REARM_FULL;
    end else if (vld) begin
      if (blank_now) begin
        unit_idx <= unit_idx + UW'(1);
        in_span  <= ~span_close;
        if (span_close)
          rearm_cnt <= '0;
      end else if (!armed) begin
        rearm_cnt <= rearm_cnt + RW'(1);
      end
    end
  end
endmodule

// File: rtl/gec_seg_flag.sv
module gec_seg_flag
  import gec_pkg::*;
#(
  parameter int SEG_BITS   = 128,
  parameter int PULSE_CLKS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic vld,
  input  logic miss,
  output logic seg_fire,
  output logic err_pulse
);
  localparam int SW = $clog2(SEG_BITS);
  localparam int PW = $clog2(PULSE_CLKS + 1);

  logic [SW-1:0] pos;
  logic          hit_q;
  logic          seg_last;
  logic [PW-1:0] left_q;

  assign seg_last  = vld & at_last(int'(pos), SEG_BITS);
  assign seg_fire  = seg_last & (hit_q | miss);
  assign err_pulse = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      hit_q  <= 1'b0;
      left_q <= '0;
    end else if (clr) begin
      pos    <= '0;
      hit_q  <= 1'b0;
      left_q <= '0;
    end else begin
      if (vld) begin
        pos   <= pos + SW'(1);
        hit_q <= seg_last ? 1'b0 : (hit_q | miss);
      end
      if (seg_fire)
        left_q <= PW'(PULSE_CLKS);
      else if (left_q != '0)
        left_q <= left_q - PW'(1);
    end
  end
endmodule

// File: rtl/gated_err_counter.sv
module gated_err_counter
  import gec_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int ERR_W      = 32,
  parameter int UNIT_BITS  = 512,
  parameter int SEG_BITS   = 128,
  parameter int PULSE_CLKS = 128,
  parameter int REARM_BITS = 2560
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_vld,
  input  logic             rx_bit,
  input  logic             exp_bit,
  input  logic             gate,
  output logic [CNT_W-1:0] bits_cmp,
  output logic [ERR_W-1:0] err_exp0,
  output logic [ERR_W-1:0] err_exp1,
  output logic [ERR_W-1:0] err_all,
  output logic             err_pulse
);
  // Named internal events, shared with the bound checker.
  logic                 blank_now;
  logic                 span_close;
  logic                 cmp_bit;
  logic [NUM_KINDS-1:0] miss_k;
  logic                 seg_fire;
  logic [ERR_W-1:0]     err_val [NUM_KINDS];

  gec_blank #(
    .UNIT_BITS (UNIT_BITS),
    .REARM_BITS(REARM_BITS)
  ) u_blank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .vld       (bit_vld),
    .gate      (gate),
    .blank_now (blank_now),
    .span_close(span_close)
  );

  assign cmp_bit = bit_vld & ~blank_now;
  assign miss_k  = miss_vec(cmp_bit, rx_bit, exp_bit);

  gec_sat_cnt #(.W(CNT_W)) u_bits (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .inc  (cmp_bit),
    .value(bits_cmp)
  );

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_err
    gec_sat_cnt #(.W(ERR_W)) u_err (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .inc  (miss_k[k]),
      .value(err_val[k])
    );
  end

  assign err_exp0 = err_val[KIND_EXP0];
  assign err_exp1 = err_val[KIND_EXP1];
  assign err_all  = err_val[KIND_ANY];

  gec_seg_flag #(
    .SEG_BITS  (SEG_BITS),
    .PULSE_CLKS(PULSE_CLKS)
  ) u_seg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .vld      (bit_vld),
    .miss     (miss_k[KIND_ANY]),
    .seg_fire (seg_fire),
    .err_pulse(err_pulse)
  );
endmodule

// File: rtl/gec_chk.sv
module gec_chk #(
  parameter int CNT_W      = 32,
  parameter int ERR_W      = 32,
  parameter int UNIT_BITS  = 512,
  parameter int SEG_BITS   = 128,
  parameter int PULSE_CLKS = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             vld,
  input logic             blank_now,
  input logic             span_close,
  input logic             seg_fire,
  input logic [CNT_W-1:0] bits_cmp,
  input logic [ERR_W-1:0] err_exp0,
  input logic [ERR_W-1:0] err_exp1,
  input logic [ERR_W-1:0] err_all,
  input logic             err_pulse
);
  localparam int SW = $clog2(SEG_BITS);
  localparam logic [ERR_W-1:0] EMAX = '1;

  logic [31:0]   run_len;
  logic [31:0]   blank_run;
  logic [SW-1:0] chk_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= '0;
      blank_run <= '0;
      chk_pos   <= '0;
    end else begin
      run_len <= err_pulse ? run_len + 32'd1 : 32'd0;
      if (clr) begin
        blank_run <= '0;
        chk_pos   <= '0;
      end else begin
        if (vld)
          chk_pos <= chk_pos + SW'(1);
        if (span_close)
          blank_run <= '0;
        else if (vld && blank_now)
          blank_run <= blank_run + 32'd1;
      end
    end
  end

  a_r2_bits_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (32'(bits_cmp) == 32'($past(bits_cmp)) ||
              32'(bits_cmp) == 32'($past(bits_cmp)) + 32'd1));

  a_r3_split_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (err_all != EMAX) |-> (32'(err_all) == 32'(err_exp0) + 32'(err_exp1)));

  a_r4_pulse_on_seg_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_pulse) |-> ($past(vld) && chk_pos == '0));

  a_r4_fire_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_fire && !clr) |=> err_pulse);

  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_pulse) && !$past(clr)) |-> (run_len % PULSE_CLKS == 0));

  a_r6_span_units: assert property (@(posedge clk) disable iff (!rst_n || clr)
    span_close |-> ((blank_run + 32'd1) % UNIT_BITS == 0));

  a_r7_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && blank_now && !clr) |=> ($stable(bits_cmp) && $stable(err_all)));

  a_r9_err_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (err_all == EMAX && !clr) |=> (err_all == EMAX));
endmodule

bind gated_err_counter gec_chk #(
  .CNT_W     (CNT_W),
  .ERR_W     (ERR_W),
  .UNIT_BITS (UNIT_BITS),
  .SEG_BITS  (SEG_BITS),
  .PULSE_CLKS(PULSE_CLKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .vld       (bit_vld),
  .blank_now (blank_now),
  .span_close(span_close),
  .seg_fire  (seg_fire),
  .bits_cmp  (bits_cmp),
  .err_exp0  (err_exp0),
  .err_exp1  (err_exp1),
  .err_all   (err_all),
  .err_pulse (err_pulse)
);

// File: tb/sim_gated_err_counter.sv
module sim_gated_err_counter;
  localparam int CW = 16;
  localparam int EW = 6;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic vld = 1'b0, rxb = 1'b0, expb = 1'b0, gate = 1'b0;
  logic [CW-1:0] bits_cmp;
  logic [EW-1:0] err_exp0, err_exp1, err_all;
  logic err_pulse;

  always #5 clk = ~clk;

  gated_err_counter #(.CNT_W(CW), .ERR_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(vld), .rx_bit(rxb),
    .exp_bit(expb), .gate(gate), .bits_cmp(bits_cmp), .err_exp0(err_exp0),
    .err_exp1(err_exp1), .err_all(err_all), .err_pulse(err_pulse)
  );

  int n_chk = 0;
  int n_err = 0;
  int pulse_hi = 0;

  always @(negedge clk) if (err_pulse) pulse_hi++;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic v, logic r, logic e, logic g, logic c);
    @(negedge clk);
    vld = v; rxb = r; expb = e; gate = g; clr = c;
  endtask

  task automatic idle(int n);
    repeat (n) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // len, ref kind (0 zeros, 1 ones, 2 alternating), flip period,
  // invalid gap after each bit, bits delta, exp0 error delta, exp1 error delta
  localparam int TBL [6][7] = '{
    '{100, 0,  0, 0, 100,  0,  0},
    '{ 60, 1, 10, 0,  60,  0,  6},
    '{ 40, 0,  8, 0,  40,  5,  0},
    '{ 64, 2,  4, 0,  64,  0, 16},
    '{ 50, 2,  5, 0,  50,  5,  5},
    '{ 30, 0,  3, 1,  30, 10,  0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int b0, z0, o0, a0, p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset bits", int'(bits_cmp), 0);
    chk("R1 reset exp0", int'(err_exp0), 0);
    chk("R1 reset exp1", int'(err_exp1), 0);
    chk("R1 reset all", int'(err_all), 0);
    chk("R1 reset pulse", int'(err_pulse), 0);
    rst_n = 1'b1;

    // R2 R3 table of streams
    for (int k = 0; k < 6; k++) begin
      b0 = int'(bits_cmp); z0 = int'(err_exp0);
      o0 = int'(err_exp1); a0 = int'(err_all);
      for (int i = 0; i < TBL[k][0]; i++) begin
        logic rb, fl;
        rb = (TBL[k][1] == 2) ? logic'(i % 2) : logic'(TBL[k][1] == 1);
        fl = (TBL[k][2] != 0) && ((i % TBL[k][2]) == TBL[k][2] - 1);
        step(1'b1, rb ^ fl, rb, 1'b0, 1'b0);
        if (TBL[k][3] != 0) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      end
      idle(1);
      chk("R2 table bits", int'(bits_cmp) - b0, TBL[k][4]);
      chk("R3 table exp0", int'(err_exp0) - z0, TBL[k][5]);
      chk("R3 table exp1", int'(err_exp1) - o0, TBL[k][6]);
      chk("R3 table all", int'(err_all) - a0, TBL[k][5] + TBL[k][6]);
    end

    // R4 R5 error segment pulse
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (127) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    p0 = pulse_hi;
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R4 pulse after seg end", int'(err_pulse), 1);
    idle(139);
    chk("R5 pulse length", pulse_hi - p0, 128);
    p0 = pulse_hi;
    repeat (128) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(140);
    chk("R4 clean segment no pulse", pulse_hi - p0, 0);

    // R6 R7 blanked span rounded to one unit
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (10) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    p0 = pulse_hi;
    repeat (100) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    repeat (411) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R7 blanked bits not counted", int'(bits_cmp), 10);
    chk("R7 blanked errors not counted", int'(err_all), 0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R6 bit 512 of unit still blanked", int'(err_all), 0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R6 compare resumes after unit", int'(err_exp0), 1);
    chk("R6 bits after unit", int'(bits_cmp), 11);
    chk("R7 no pulse from blanked errors", pulse_hi - p0, 0);

    // R8 rearm window after a span
    repeat (5) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    idle(1);
    chk("R8 gate ignored while disarmed bits", int'(bits_cmp), 16);
    chk("R8 gate ignored while disarmed errs", int'(err_exp0), 6);
    repeat (2553) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    idle(1);
    chk("R8 bit 2560 still compared", int'(err_exp0), 7);
    chk("R8 bit 2560 counted", int'(bits_cmp), 2570);
    repeat (599) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    repeat (425) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R6 two-unit span bits", int'(bits_cmp), 2570);
    chk("R6 two-unit span errs", int'(err_exp0), 7);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R6 compare after two units", int'(err_exp0), 8);

    // R4 R7 segment end and gate start in the same bit, then R1 clear
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (50) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (76) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    idle(1);
    chk("R4 pulse with blanked last bit", int'(err_pulse), 1);
    chk("R7 blanked last bit error ignored", int'(err_all), 1);
    chk("R7 blanked last bit not counted", int'(bits_cmp), 127);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(1);
    chk("R1 clear ends pulse", int'(err_pulse), 0);
    chk("R1 clear bits", int'(bits_cmp), 0);

    // R9 saturation
    repeat (70) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    idle(1);
    chk("R9 exp1 saturates", int'(err_exp1), 63);
    chk("R9 all saturates", int'(err_all), 63);
    chk("R9 exp0 untouched", int'(err_exp0), 0);
    chk("R9 bits", int'(bits_cmp), 70);

    // R1 clear wins over a bit in the same cycle
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    idle(1);
    chk("R1 clear priority bits", int'(bits_cmp), 0);
    chk("R1 clear priority exp0", int'(err_exp0), 0);
    chk("R1 clear priority all", int'(err_all), 0);

    // R2 invalid cycles ignored
    repeat (20) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk("R2 invalid bits ignored", int'(bits_cmp), 0);
    chk("R2 invalid errors ignored", int'(err_all), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule